// File: doc/BRIEF.md
# GPIO Bank with Edge Detection

A bank of up to 32 general-purpose pins behind a simple synchronous register port. Software drives output levels through a pair of write-one-to-set and write-one-to-clear words, so a single bus write changes chosen pins without disturbing the others. Direction is held per pin, with an elaboration-time mask that flips the sense of the direction bit for selected pins.

Incoming pin levels pass through a multi-flop synchronizer. Enabled rising and falling transitions latch into a sticky status word, cleared by writing ones. A mask word decides which latched bits reach the pending-interrupt vector. A two-bit-per-pin function-select field reports which pins are in plain GPIO use.

Top module: `gpio_edge_bank`

## Requirements
- R1: After reset the direction, output, rising-enable, falling-enable, status, function-select and mask registers read zero, `pin_out` is zero, `irq_pend` is zero and `pin_oe` equals `INV_MASK`.
- R2: A write to the set word (0x18) drives high every `pin_out` bit whose data bit is 1. A write to the clear word (0x24) drives low every such bit. Zero bits leave outputs unchanged. Both words read as zero.
- R3: A direction bit of 1 enables the output driver (`pin_oe`=1) for a normal pin. For a pin whose `INV_MASK` bit is 1, the sense is reversed (a direction bit of 1 means input). The direction word (0x0C) reads back as written.
- R4: A status bit (word 0x48) sets when the synchronized pin rises with its rising-enable bit (0x30) at 1, or falls with its falling-enable bit (0x3C) at 1. With both enables set, both kinds of transition are caught. With neither set, the bit stays 0.
- R5: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R6: When a transition and a clearing write hit the same status bit in the same cycle, the bit stays set.
- R7: The level word (0x00) returns the pin inputs after the synchronizer, whatever the direction. A pin change is visible to a read two clock edges later. Writes to the level word have no effect.
- R8: `irq_pend` equals status AND edge mask (word 0x9C). A masked status bit stays latched and still reads back in the status word.
- R9: Function-select holds 2 bits per pin. Pins 0..15 are at word 0x54 and pins 16..31 at word 0x58, with pin n at bits [2*(n mod 16)+1 : 2*(n mod 16)]. `gpio_sel[n]` is 1 when the field is 0 on a normal pin, or 1 on an inverted pin.
- R10: Read data appears on `bus_rdata` one clock after the edge that samples `bus_rd`. Unmapped words read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte address of the register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | NPINS | Raw pin levels |
| pin_out | output | NPINS | Output data per pin |
| pin_oe | output | NPINS | Output enable per pin |
| gpio_sel | output | NPINS | Pin is in plain GPIO use |
| irq_pend | output | NPINS | Masked pending-edge vector |

## Verification
The clearing write to the status word can land in the same cycle as a freshly detected transition. The bench provokes this by changing a pin and timing an all-ones clear so that it is sampled on the exact edge where the transition latches. It then repeats the clear one cycle later. Judged by reading status back: in the first case the new pin's bit must survive while older bits are cleared, and in the second case everything must be cleared.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
   localparam int ADDR_W = 8;
   localparam int DATA_W = 32;
   localparam logic [ADDR_W-1:0] A_LEVEL = 8'h00;
   localparam logic [ADDR_W-1:0] A_DIR   = 8'h0C;
   localparam logic [ADDR_W-1:0] A_SET   = 8'h18;
   localparam logic [ADDR_W-1:0] A_CLR   = 8'h24;
   localparam logic [ADDR_W-1:0] A_RISE  = 8'h30;
   localparam logic [ADDR_W-1:0] A_FALL  = 8'h3C;
   localparam logic [ADDR_W-1:0] A_STAT  = 8'h48;
   localparam logic [ADDR_W-1:0] A_FSEL0 = 8'h54;
   localparam logic [ADDR_W-1:0] A_FSEL1 = 8'h58;
   localparam logic [ADDR_W-1:0] A_MASK  = 8'h9C;
   localparam int FSEL_PER_WORD = 16;
endpackage

// File: rtl/gpio_edge_sync.sv
module gpio_edge_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_in,
   output logic [W-1:0] q_out
);
   if (STAGES < 2) begin : g_bad
      $error("gpio_edge_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      end else begin
         stg[0] <= d_in;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q_out = stg[STAGES-1];
endmodule

// File: rtl/gpio_edge_status.sv
module gpio_edge_status #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl,
   input  logic [W-1:0] rise_en,
   input  logic [W-1:0] fall_en,
   input  logic         clr_en,
   input  logic [W-1:0] clr_bits,
   output logic [W-1:0] status
);
   logic [W-1:0] prev_q;
   logic [W-1:0] hit;
   logic [W-1:0] wipe;

   always_comb begin
      hit  = (lvl & ~prev_q & rise_en) | (~lvl & prev_q & fall_en);
      wipe = clr_en ? clr_bits : '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q <= '0;
         status <= '0;
      end else begin
         prev_q <= lvl;
         status <= (status & ~wipe) | hit;
      end
   end

   AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (|hit) |=> ((status & $past(hit)) == $past(hit))); // R6

   AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      clr_en |=> ((status & $past(clr_bits) & ~$past(hit)) == '0)); // R5

   AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
      (((rise_en | fall_en) == '0) && (status == '0)) |=> (status == '0)); // R4
endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
   import gpio_edge_pkg::*;
#(
   parameter int               NPINS       = 32,
   parameter logic [31:0]      INV_MASK    = 32'hF000_0000,
   parameter int               SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [7:0]        bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [NPINS-1:0]  pin_in,
   output logic [NPINS-1:0]  pin_out,
   output logic [NPINS-1:0]  pin_oe,
   output logic [NPINS-1:0]  gpio_sel,
   output logic [NPINS-1:0]  irq_pend
);
   localparam int FSEL_W = 2 * NPINS;
   localparam logic [NPINS-1:0] INV = INV_MASK[NPINS-1:0];

   if (NPINS < 1 || NPINS > DATA_W) begin : g_bad_width
      $error("gpio_edge_bank: NPINS must be 1..32");
   end

   logic [NPINS-1:0]  dir_q, out_q, rise_q, fall_q, mask_q;
   logic [FSEL_W-1:0] fsel_q;
   logic [NPINS-1:0]  lvl;
   logic [NPINS-1:0]  stat;
   logic [NPINS-1:0]  wd;
   logic [63:0]       fsel_view;
   logic              wr_stat;

   assign wd      = bus_wdata[NPINS-1:0];
   assign wr_stat = bus_wr && (bus_addr == A_STAT);

   gpio_edge_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (pin_in),
      .q_out (lvl)
   );

   gpio_edge_status #(.W(NPINS)) edge_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .lvl      (lvl),
      .rise_en  (rise_q),
      .fall_en  (fall_q),
      .clr_en   (wr_stat),
      .clr_bits (wd),
      .status   (stat)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dir_q  <= '0;
         out_q  <= '0;
         rise_q <= '0;
         fall_q <= '0;
         mask_q <= '0;
      end else if (bus_wr) begin
         case (bus_addr)
            A_DIR:  dir_q  <= wd;
            A_SET:  out_q  <= out_q | wd;
            A_CLR:  out_q  <= out_q & ~wd;
            A_RISE: rise_q <= wd;
            A_FALL: fall_q <= wd;
            A_MASK: mask_q <= wd;
            default: ;
         endcase
      end
   end

   for (genvar n = 0; n < NPINS; n++) begin : g_fsel
      localparam int WORD = n / FSEL_PER_WORD;
      localparam int POS  = 2 * (n % FSEL_PER_WORD);
      localparam logic [7:0] FADDR = (WORD == 0) ? A_FSEL0 : A_FSEL1;
      localparam logic [1:0] PLAIN = INV[n] ? 2'd1 : 2'd0;

      always_ff @(posedge clk) begin
         if (!rst_n) fsel_q[2*n +: 2] <= 2'd0;
         else if (bus_wr && bus_addr == FADDR) fsel_q[2*n +: 2] <= bus_wdata[POS +: 2];
      end

      assign gpio_sel[n] = (fsel_q[2*n +: 2] == PLAIN);
   end

   always_comb begin
      fsel_view = '0;
      fsel_view[FSEL_W-1:0] = fsel_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_rdata <= '0;
      end else if (bus_rd) begin
         bus_rdata <= '0;
         case (bus_addr)
            A_LEVEL: bus_rdata[NPINS-1:0] <= lvl;
            A_DIR:   bus_rdata[NPINS-1:0] <= dir_q;
            A_RISE:  bus_rdata[NPINS-1:0] <= rise_q;
            A_FALL:  bus_rdata[NPINS-1:0] <= fall_q;
            A_STAT:  bus_rdata[NPINS-1:0] <= stat;
            A_MASK:  bus_rdata[NPINS-1:0] <= mask_q;
            A_FSEL0: bus_rdata <= fsel_view[31:0];
            A_FSEL1: bus_rdata <= fsel_view[63:32];
            default: ;
         endcase
      end else begin
         bus_rdata <= '0;
      end
   end

   assign pin_out  = out_q;
   assign pin_oe   = dir_q ^ INV;
   assign irq_pend = stat & mask_q;

   AST_SET_DRIVES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_SET) |=> ((pin_out & $past(wd)) == $past(wd))); // R2

   AST_CLR_DRIVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_CLR) |=> ((pin_out & $past(wd)) == '0)); // R2

   AST_DIR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && bus_addr == A_DIR) |=> $stable(pin_oe)); // R3

   AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> (bus_rdata == '0)); // R10
endmodule

// File: tb/gpio_edge_bank_tb_top.sv
module gpio_edge_bank_tb_top;
   localparam int NP = 32;
   localparam logic [31:0] INV = 32'hF000_0000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [NP-1:0] pin_in = '0;
   logic [NP-1:0] pin_out, pin_oe, gpio_sel, irq_pend;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   gpio_edge_bank #(.NPINS(NP), .INV_MASK(INV), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
      .gpio_sel(gpio_sel), .irq_pend(irq_pend)
   );

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [31:0] hits(input logic [31:0] o, input logic [31:0] n,
                                        input logic [31:0] r, input logic [31:0] f);
      return (n & ~o & r) | (~n & o & f);
   endfunction

   function automatic logic [31:0] sel_of(input logic [63:0] fs);
      logic [31:0] s;
      for (int i = 0; i < 32; i++) s[i] = (fs[2*i +: 2] == (INV[i] ? 2'd1 : 2'd0));
      return s;
   endfunction

   initial begin
      int unsigned seed_dummy;
      repeat (50000) @(posedge clk);
      fails++;
      $display("FAIL watchdog got=%h exp=%h", 32'd1, 32'd0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [31:0] d, exp_out, exp_dir, exp_rise, exp_fall, exp_stat, exp_mask, pins_old, v;
      logic [63:0] exp_fs;
      void'($urandom(32'd7001));
      idle(3);
      rst_n = 1'b1;
      idle(1);

      // R1 reset state
      chk("R1 pin_out", pin_out, 32'h0);
      chk("R1 pin_oe", pin_oe, INV);
      chk("R1 irq_pend", irq_pend, 32'h0);
      rd(8'h0C, d); chk("R1 dir", d, 32'h0);
      rd(8'h48, d); chk("R1 status", d, 32'h0);
      rd(8'h9C, d); chk("R1 mask", d, 32'h0);
      rd(8'h54, d); chk("R1 fsel0", d, 32'h0);

      // R2 set/clear
      exp_out = '0;
      wr(8'h18, 32'h0000_00F3); exp_out |= 32'h0000_00F3;
      chk("R2 set", pin_out, exp_out);
      wr(8'h24, 32'h0000_0021); exp_out &= ~32'h0000_0021;
      chk("R2 clear", pin_out, exp_out);
      rd(8'h18, d); chk("R2 set word reads zero", d, 32'h0);
      wr(8'h18, 32'h0); chk("R2 zero write", pin_out, exp_out);

      // R3 direction polarity
      exp_dir = 32'h3000_00FF;
      wr(8'h0C, exp_dir);
      chk("R3 oe polarity", pin_oe, exp_dir ^ INV);
      rd(8'h0C, d); chk("R3 dir readback", d, exp_dir);

      // R7 level, regardless of direction; level word write ignored
      pin_in = 32'hA5A5_0F0F;
      idle(2);
      rd(8'h00, d); chk("R7 level", d, 32'hA5A5_0F0F);
      wr(8'h00, 32'hFFFF_FFFF);
      rd(8'h00, d); chk("R7 level write ignored", d, 32'hA5A5_0F0F);
      rd(8'h60, d); chk("R10 unmapped", d, 32'h0);

      // R4 edges with both, rise-only, fall-only, none
      wr(8'h48, 32'hFFFF_FFFF);
      exp_rise = 32'h0000_00FF; exp_fall = 32'h0000_F0F0;
      wr(8'h30, exp_rise); wr(8'h3C, exp_fall);
      pins_old = pin_in;
      pin_in = 32'h5A5A_F0F0;
      exp_stat = hits(pins_old, pin_in, exp_rise, exp_fall);
      idle(4);
      rd(8'h48, d); chk("R4 directed edges", d, exp_stat);

      // R8 mask gating
      chk("R8 masked irq zero", irq_pend, 32'h0);
      exp_mask = 32'h0000_000F;
      wr(8'h9C, exp_mask);
      chk("R8 irq gated", irq_pend, exp_stat & exp_mask);
      rd(8'h48, d); chk("R8 masked bits still latched", d, exp_stat);

      // R5 write-one-to-clear, zero no effect
      wr(8'h48, 32'h0);
      rd(8'h48, d); chk("R5 zero write", d, exp_stat);
      wr(8'h48, 32'h0000_0003); exp_stat &= ~32'h3;
      rd(8'h48, d); chk("R5 partial clear", d, exp_stat);
      wr(8'h48, 32'hFFFF_FFFF); exp_stat = '0;
      rd(8'h48, d); chk("R5 clear all", d, 32'h0);

      // R6 collision: edge latches on same edge as clearing write
      wr(8'h30, 32'hFFFF_FFFF); wr(8'h3C, 32'h0);
      pin_in = '0; idle(4);
      pin_in = 32'h0000_0008; idle(4);
      @(negedge clk); pin_in = 32'h0000_0028;
      @(negedge clk); @(negedge clk);
      bus_wr = 1'b1; bus_addr = 8'h48; bus_wdata = 32'hFFFF_FFFF;
      @(negedge clk); bus_wr = 1'b0; bus_wdata = '0;
      rd(8'h48, d); chk("R6 edge wins over clear", d, 32'h0000_0020);
      // one cycle later the clear wins
      wr(8'h48, 32'hFFFF_FFFF);
      @(negedge clk); pin_in = 32'h0000_0068;
      @(negedge clk); @(negedge clk); @(negedge clk);
      bus_wr = 1'b1; bus_addr = 8'h48; bus_wdata = 32'hFFFF_FFFF;
      @(negedge clk); bus_wr = 1'b0; bus_wdata = '0;
      rd(8'h48, d); chk("R6 clear after latch", d, 32'h0);

      // R9 function select
      exp_fs = {32'h4000_0000, 32'h0000_0006};
      wr(8'h54, exp_fs[31:0]); wr(8'h58, exp_fs[63:32]);
      chk("R9 gpio_sel", gpio_sel, sel_of(exp_fs));
      rd(8'h58, d); chk("R9 fsel1 readback", d, exp_fs[63:32]);

      // random mix
      wr(8'h48, 32'hFFFF_FFFF); exp_stat = '0;
      wr(8'h9C, 32'hFFFF_FFFF); exp_mask = '1;
      pins_old = pin_in;
      for (int it = 0; it < 60; it++) begin
         int op;
         op = $urandom_range(0, 3);
         v = $urandom;
         case (op)
            0: begin wr(8'h18, v); exp_out |= v; chk("R2 random set", pin_out, exp_out); end
            1: begin wr(8'h24, v); exp_out &= ~v; chk("R2 random clear", pin_out, exp_out); end
            2: begin wr(8'h0C, v); chk("R3 random dir", pin_oe, v ^ INV); end
            default: begin
               exp_rise = $urandom; exp_fall = $urandom;
               wr(8'h30, exp_rise); wr(8'h3C, exp_fall);
               pin_in = v;
               exp_stat |= hits(pins_old, v, exp_rise, exp_fall);
               pins_old = v;
               idle(4);
               rd(8'h48, d); chk("R4 random edges", d, exp_stat);
               chk("R8 random irq", irq_pend, exp_stat & exp_mask);
               v = $urandom;
               wr(8'h48, v); exp_stat &= ~v;
               rd(8'h48, d); chk("R5 random clear", d, exp_stat);
            end
         endcase
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule